// File: doc/BRIEF.md
# Lossy Last-Value Fast Channel Array

This block is a bank of single-word channels that a sending agent can overwrite at any moment and a receiving agent can read at any moment. It behaves like a small register file in which every sender write also raises an interrupt for the written channel. There is no flow control and no acknowledge path. A write that lands on a channel the receiver has not yet read replaces the old word without any indication. The interrupt only says that at least one write has happened since the receiver last cleared it.

Each channel has a pending bit. A sender write sets it, and the receiver clears it by writing ones through a group-indexed mask. Channels are also gathered into fixed-size groups. Each group drives one level interrupt that is the OR of its members' pending bits, so a receiver can service a group line instead of watching every per-channel line.

The channel count, word width and group size are build-time parameters. The word width must be 32 or 64. The channel count runs from 1 to 1024 for 32-bit words and from 1 to 512 for 64-bit words. Software reads the channel count and word width from a constant information word. The asynchronous reset is released through a two-stage synchronizer.

Top module: `fastchan_hub`

## Requirements
- R1: After reset release, every per-channel and group interrupt is low and every channel reads as zero.
- R2: A sender write to channel c with c below the channel count stores the word, and the combinational read of c returns it from the cycle after the write edge.
- R3: A later write to the same channel replaces the stored word whether or not the earlier word was read. Reads always return the most recent word.
- R4: A sender write to an existing channel sets that channel's pending bit, seen as `irq_ch[c]` high one cycle after the write edge. The bit stays high at every later edge until the receiver clears it.
- R5: A clear with group index g and mask m clears the pending bit of channel g*GROUP_SZ+i for each set bit i of m. Channels whose mask bit is zero keep their state.
- R6: If a sender write and a receiver clear hit the same channel in the same cycle, that channel's pending bit is set after the edge.
- R7: `irq_grp[g]` is high exactly when at least one of channels g*GROUP_SZ to g*GROUP_SZ+GROUP_SZ-1 (the existing ones) has its pending bit set.
- R8: Writes to a channel index at or above the channel count change no interrupt and no stored word, and reads of such an index return zero. Clears with a group index at or above the group count, and mask bits that point past the last channel, have no effect.
- R9: `cfg_info` bits [15:0] hold the channel count, bits [23:16] hold the word width in bits, and bits [31:24] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| snd_wr_en | input | 1 | Sender write strobe |
| snd_wr_ch | input | CH_AW | Sender channel index |
| snd_wr_data | input | WORD_W | Sender word |
| rcv_rd_ch | input | CH_AW | Receiver read channel index |
| rcv_rd_data | output | WORD_W | Stored word of the addressed channel (combinational) |
| rcv_clr_en | input | 1 | Receiver write-one-to-clear strobe |
| rcv_clr_grp | input | GW | Group index for the clear |
| rcv_clr_mask | input | GROUP_SZ | Per-member clear bits within the group |
| irq_ch | output | NUM_CH | Per-channel level transfer interrupts |
| irq_grp | output | NUM_GRP | Per-group level transfer interrupts |
| cfg_info | output | 32 | Read-only channel count and word width |

## Verification
If a pending bit is set or dropped wrongly, it shows on its `irq_ch` line and on its group line in the cycle after the edge that caused it. A misplaced stored word shows on `rcv_rd_data` as soon as the bench addresses that channel, which it does after every step. Write-versus-clear collisions, partial last groups and out-of-range indices are each driven on purpose. Random steps then compare the whole interrupt state every cycle.

// File: rtl/fc_pkg.sv
package fc_pkg;

  // Build the read-only information word: count low, width above it.
  function automatic logic [31:0] fc_cfg_word(input int unsigned nch, input int unsigned wbits);
    logic [31:0] w;
    w = '0;
    w[15:0]  = nch[15:0];
    w[23:16] = wbits[7:0];
    return w;
  endfunction

  function automatic int unsigned fc_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fc_rst_sync.sv
module fc_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/fc_store.sv
module fc_store #(
  parameter int NUM_CH = 10,
  parameter int WORD_W = 32,
  parameter int CH_AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_AW-1:0]  wr_ch,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CH_AW-1:0]  rd_ch,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] words_q [NUM_CH];
  logic [WORD_W-1:0] words_d [NUM_CH];
  logic [NUM_CH-1:0] wr_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_word
      assign wr_hit[gi] = wr_en && (wr_ch == CH_AW'(gi));

      always_comb begin
        words_d[gi] = wr_hit[gi] ? wr_data : words_q[gi];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          words_q[gi] <= '0;
        else if (wr_hit[gi]) words_q[gi] <= words_d[gi];
      end

      // R3: a word only moves when its own channel is written
      assert_word_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit[gi] |=> $stable(words_q[gi]));
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_ch == CH_AW'(i)) rd_data = words_q[i];
    end
  end

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ({1'b0, wr_ch} < (CH_AW+1)'(NUM_CH))) |=> (words_q[$past(wr_ch)] == $past(wr_data)));

endmodule

// File: rtl/fc_pending.sv
module fc_pending #(
  parameter int NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] pend_q
);

  logic [NUM_CH-1:0] pend_d;
  logic              pend_upd;

  always_comb begin
    // the set is applied after the clear, so a write wins a collision
    pend_d   = (pend_q & ~clr_vec) | set_vec;
    pend_upd = |(set_vec | clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= '0;
    else if (pend_upd) pend_q <= pend_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_chk
      // R4 and R6: a write always leaves the bit set
      assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[gi] |=> pend_q[gi]);
      assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[gi] && !set_vec[gi]) |=> !pend_q[gi]);
      assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[gi] && !clr_vec[gi]) |=> pend_q[gi]);
      assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[gi]) |-> $past(set_vec[gi]));
    end
  endgenerate

endmodule

// File: rtl/fc_group_irq.sv
module fc_group_irq #(
  parameter int NUM_CH   = 10,
  parameter int GROUP_SZ = 4,
  parameter int NUM_GRP  = 3
) (
  input  logic [NUM_CH-1:0]  pend,
  output logic [NUM_GRP-1:0] irq_grp
);

  localparam int PAD_W = NUM_GRP * GROUP_SZ;

  logic [PAD_W-1:0] pend_pad;

  generate
    if (PAD_W > NUM_CH) begin : g_pad
      assign pend_pad = {{(PAD_W-NUM_CH){1'b0}}, pend};
    end else begin : g_nopad
      assign pend_pad = pend;
    end
  endgenerate

  genvar gg;
  generate
    for (gg = 0; gg < NUM_GRP; gg++) begin : g_or
      assign irq_grp[gg] = |pend_pad[gg*GROUP_SZ +: GROUP_SZ];
    end
  endgenerate

endmodule

// File: rtl/fastchan_hub.sv
module fastchan_hub #(
  parameter int NUM_CH      = 10,
  parameter int WORD_W      = 32,
  parameter int GROUP_SZ    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CH_AW      = fc_pkg::fc_idx_w(NUM_CH),
  localparam int NUM_GRP    = (NUM_CH + GROUP_SZ - 1) / GROUP_SZ,
  localparam int GW         = fc_pkg::fc_idx_w(NUM_GRP)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snd_wr_en,
  input  logic [CH_AW-1:0]    snd_wr_ch,
  input  logic [WORD_W-1:0]   snd_wr_data,
  input  logic [CH_AW-1:0]    rcv_rd_ch,
  output logic [WORD_W-1:0]   rcv_rd_data,
  input  logic                rcv_clr_en,
  input  logic [GW-1:0]       rcv_clr_grp,
  input  logic [GROUP_SZ-1:0] rcv_clr_mask,
  output logic [NUM_CH-1:0]   irq_ch,
  output logic [NUM_GRP-1:0]  irq_grp,
  output logic [31:0]         cfg_info
);

  localparam int PAD_W = NUM_GRP * GROUP_SZ;

  logic              srst_n;
  logic [NUM_CH-1:0] set_vec;
  logic [PAD_W-1:0]  clr_pad;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] pend_q;
  logic              wr_oob;

  fc_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // write decode: indices past the last channel select nothing
  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_set
      assign set_vec[gi] = snd_wr_en && (snd_wr_ch == CH_AW'(gi));
    end
  endgenerate

  // clear decode: one mask slice per group, out-of-range group matches none
  genvar gg;
  generate
    for (gg = 0; gg < NUM_GRP; gg++) begin : g_clr
      assign clr_pad[gg*GROUP_SZ +: GROUP_SZ] =
        (rcv_clr_en && (rcv_clr_grp == GW'(gg))) ? rcv_clr_mask : '0;
    end
  endgenerate

  assign clr_vec = clr_pad[NUM_CH-1:0];
  assign wr_oob  = snd_wr_en && ({1'b0, snd_wr_ch} >= (CH_AW+1)'(NUM_CH));

  fc_store #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .CH_AW(CH_AW)) u_store (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (snd_wr_en),
    .wr_ch   (snd_wr_ch),
    .wr_data (snd_wr_data),
    .rd_ch   (rcv_rd_ch),
    .rd_data (rcv_rd_data)
  );

  fc_pending #(.NUM_CH(NUM_CH)) u_pend (
    .clk     (clk),
    .rst_n   (srst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .pend_q  (pend_q)
  );

  fc_group_irq #(.NUM_CH(NUM_CH), .GROUP_SZ(GROUP_SZ), .NUM_GRP(NUM_GRP)) u_grp (
    .pend    (pend_q),
    .irq_grp (irq_grp)
  );

  assign irq_ch   = pend_q;
  assign cfg_info = fc_pkg::fc_cfg_word(NUM_CH, WORD_W);

  assert_oob_ignored_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_oob && !rcv_clr_en) |=> $stable(irq_ch));

  assert_grp_rise_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_grp == '0 && !snd_wr_en) |=> (irq_grp == '0));

endmodule

// File: tb/fastchan_hub_test.sv
module fastchan_hub_test;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 10;
  localparam int WW   = 32;
  localparam int GS   = 4;
  localparam int AW   = 4;
  localparam int NGRP = 3;
  localparam int GW   = 2;

  logic           clk;
  logic           rst_n;
  logic           snd_wr_en;
  logic [AW-1:0]  snd_wr_ch;
  logic [WW-1:0]  snd_wr_data;
  logic [AW-1:0]  rcv_rd_ch;
  logic [WW-1:0]  rcv_rd_data;
  logic           rcv_clr_en;
  logic [GW-1:0]  rcv_clr_grp;
  logic [GS-1:0]  rcv_clr_mask;
  logic [NCH-1:0] irq_ch;
  logic [NGRP-1:0] irq_grp;
  logic [31:0]    cfg_info;

  fastchan_hub #(.NUM_CH(NCH), .WORD_W(WW), .GROUP_SZ(GS)) uut (
    .clk, .rst_n, .snd_wr_en, .snd_wr_ch, .snd_wr_data, .rcv_rd_ch, .rcv_rd_data,
    .rcv_clr_en, .rcv_clr_grp, .rcv_clr_mask, .irq_ch, .irq_grp, .cfg_info
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [WW-1:0]  m_mem [NCH];
  logic [NCH-1:0] m_pend;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [NGRP-1:0] exp_grp(input logic [NCH-1:0] p);
    logic [NGRP-1:0] r;
    r = '0;
    for (int c = 0; c < NCH; c++) if (p[c]) r[c/GS] = 1'b1;
    return r;
  endfunction

  function automatic logic [WW-1:0] exp_rd(input logic [AW-1:0] ch);
    return (int'(ch) < NCH) ? m_mem[ch] : '0;
  endfunction

  task automatic check_state(input string tag);
    chk(irq_ch == m_pend, tag, 64'(irq_ch), 64'(m_pend));
    chk(irq_grp == exp_grp(m_pend), {tag, "/R7"}, 64'(irq_grp), 64'(exp_grp(m_pend)));
  endtask

  task automatic step(input bit we, input logic [AW-1:0] wc, input logic [WW-1:0] wd,
                      input bit ce, input logic [GW-1:0] cg, input logic [GS-1:0] cm,
                      input logic [AW-1:0] rc, input string tag);
    snd_wr_en = we; snd_wr_ch = wc; snd_wr_data = wd;
    rcv_clr_en = ce; rcv_clr_grp = cg; rcv_clr_mask = cm;
    @(posedge clk);
    #1;
    if (ce) begin
      for (int i = 0; i < GS; i++) begin
        int c;
        c = int'(cg) * GS + i;
        if (int'(cg) < NGRP && c < NCH && cm[i]) m_pend[c] = 1'b0;
      end
    end
    if (we && int'(wc) < NCH) begin
      m_pend[wc] = 1'b1;
      m_mem[wc]  = wd;
    end
    snd_wr_en = 1'b0; rcv_clr_en = 1'b0;
    check_state(tag);
    rcv_rd_ch = rc;
    #1;
    chk(rcv_rd_data == exp_rd(rc), {tag, "/R2 read"}, 64'(rcv_rd_data), 64'(exp_rd(rc)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    snd_wr_en = 1'b0; snd_wr_ch = '0; snd_wr_data = '0;
    rcv_rd_ch = '0; rcv_clr_en = 1'b0; rcv_clr_grp = '0; rcv_clr_mask = '0;
    m_pend = '0;
    for (int i = 0; i < NCH; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    // R1 reset state
    chk(irq_ch == '0, "R1 irq_ch", 64'(irq_ch), 64'd0);
    chk(irq_grp == '0, "R1 irq_grp", 64'(irq_grp), 64'd0);
    for (int i = 0; i < NCH; i++) begin
      rcv_rd_ch = AW'(i);
      #1 chk(rcv_rd_data == '0, "R1 read", 64'(rcv_rd_data), 64'd0);
    end
    // R9 info word
    chk(cfg_info == {8'd0, 8'd32, 16'd10}, "R9 cfg_info", 64'(cfg_info), 64'({8'd0, 8'd32, 16'd10}));

    // R2 / R4 first write
    step(1, 4'd3, 32'hA5A5_0003, 0, '0, '0, 4'd3, "R4 write ch3");
    // R3 overwrite without reading in between
    step(1, 4'd3, 32'h1111_2222, 0, '0, '0, 4'd0, "R3 overwrite 1");
    step(1, 4'd3, 32'h3333_4444, 0, '0, '0, 4'd3, "R3 overwrite 2");
    // R4 hold with idle cycles
    step(0, '0, '0, 0, '0, '0, 4'd3, "R4 hold");
    // R5 clear with zero mask bit on ch3, then real clear
    step(0, '0, '0, 1, 2'd0, 4'b0111, 4'd3, "R5 other bits");
    step(0, '0, '0, 1, 2'd0, 4'b1000, 4'd3, "R5 clear ch3");
    // R6 collision on ch5
    step(1, 4'd5, 32'hDEAD_0005, 0, '0, '0, 4'd5, "R6 prep");
    step(1, 4'd5, 32'hBEEF_0005, 1, 2'd1, 4'b0010, 4'd5, "R6 collide");
    // R7 partial last group: ch9 lights group 2
    step(1, 4'd9, 32'h0000_0009, 0, '0, '0, 4'd9, "R7 ch9");
    // R8 out-of-range write, clear of missing members and missing group
    step(1, 4'd12, 32'hFFFF_FFFF, 0, '0, '0, 4'd12, "R8 oob write");
    step(0, '0, '0, 1, 2'd2, 4'b1100, 4'd9, "R8 ghost mask");
    step(0, '0, '0, 1, 2'd3, 4'b1111, 4'd15, "R8 ghost group");
    step(0, '0, '0, 1, 2'd2, 4'b0010, 4'd9, "R5 clear ch9");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] wc;
      logic [GW-1:0] cg;
      wc = AW'($urandom_range(0, 15));
      cg = GW'($urandom_range(0, 3));
      step(($urandom_range(0, 2) != 0), wc, WW'($urandom),
           ($urandom_range(0, 3) == 0), cg, GS'($urandom),
           AW'($urandom_range(0, 15)), "R3/R4/R5/R6/R8 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule